// File: doc/BRIEF.md
# Receive-Level Driven RTS/CTS Flow Controller

This block produces the request-to-send pin of one serial channel and the permission signal that lets that channel's transmitter start a new character. In automatic mode the RTS pin is derived from how full the receive FIFO is. Two 4-bit codes set a stop level and a restart level, and each code is scaled to a byte count. Once the stop level is reached, RTS stays off until the FIFO has drained to the restart level, so the pin does not chatter around a single boundary. In manual mode the pin follows a software-held modem control bit.

On the transmit side, the block watches the clear-to-send pin when automatic CTS is enabled. The transmit permission is re-evaluated only when the transmitter is idle or on the cycle in which a character finishes. A peer that drops CTS in the middle of a character therefore never truncates that character. The FIFO, the shift registers and the baud timing sit outside this block.

Top module: `fc_flow_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `rts_pin` is high (deasserted) and `tx_permit` is 1.
- R2: With `auto_rts_en` = 1, if `rx_level` is greater than or equal to the stop level, `rts_pin` is high on the next cycle.
- R3: With `auto_rts_en` = 1, once RTS has been deasserted it stays high while `rx_level` exceeds the restart level. It is driven low again on the cycle after `rx_level` is at or below the restart level and below the stop level.
- R4: With `auto_rts_en` = 1 and RTS currently asserted, an `rx_level` below the stop level keeps `rts_pin` low on the next cycle.
- R5: `flow_thresh[3:0]` is the stop code and `flow_thresh[7:4]` is the restart code. Each level in bytes is its code times 4, covering 0 to 60.
- R6: With `auto_rts_en` = 0, `rts_pin` equals the inverse of `manual_rts` one cycle later. The halted state is cleared, so re-enabling automatic RTS starts from the asserted state.
- R7: With `auto_cts_en` = 1, on a cycle where `tx_busy` = 0 or `char_done` = 1, `tx_permit` becomes 1 if `cts_n` is low and 0 if it is high, on the next cycle.
- R8: With `auto_cts_en` = 0, `tx_permit` becomes 1 at the next update point, whatever the value of `cts_n`.
- R9: While `tx_busy` = 1 and `char_done` = 0, `tx_permit` keeps its value; a CTS change mid-character has no effect until the character completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | 7 | Receive FIFO fill count, 0 to 64 |
| flow_thresh | input | 8 | Restart code [7:4], stop code [3:0] |
| auto_rts_en | input | 1 | 1 = RTS driven from FIFO level |
| auto_cts_en | input | 1 | 1 = transmitter gated by CTS |
| manual_rts | input | 1 | Software RTS request, 1 = assert |
| cts_n | input | 1 | Clear-to-send pin, active low, already synchronized |
| tx_busy | input | 1 | Transmitter is shifting a character |
| char_done | input | 1 | One-cycle strobe at the end of a character |
| rts_pin | output | 1 | Request-to-send pin, active low |
| tx_permit | output | 1 | 1 = transmitter may begin a new character |

## Verification
The assertions assume that `cts_n` is already synchronous to `clk`, and that `rx_level` never exceeds the FIFO depth. They also assume `char_done` is meaningful only while `tx_busy` is high. The bench drives every input at the falling edge, keeps `rx_level` within 0 to 64, and raises `char_done` only as a single-cycle pulse. It sweeps all 256 code pairs across full fill-and-drain ramps, and all sixteen CTS-side input combinations from both prior permit states.

// File: rtl/fc_pkg.sv
package fc_pkg;
   typedef enum logic {
      FC_FLOW_ON     = 1'b0,
      FC_FLOW_HALTED = 1'b1
   } fc_rts_state_e;

   typedef struct packed {
      logic [3:0] resume_code;
      logic [3:0] halt_code;
   } fc_thresh_t;
endpackage

// File: rtl/fc_thresh_decode.sv
module fc_thresh_decode #(
   parameter int CODE_W = 4,
   parameter int SCALE  = 4,
   parameter int CNT_W  = 7
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [CNT_W-1:0]  bytes_o
);
   localparam int MAX_BYTES = ((1 << CODE_W) - 1) * SCALE;

   if (MAX_BYTES >= (1 << CNT_W)) begin : g_bad_width
      $error("fc_thresh_decode: scaled code does not fit the count width");
   end

   assign bytes_o = CNT_W'(code_i) * CNT_W'(SCALE);
endmodule

// File: rtl/fc_rts_hyst.sv
module fc_rts_hyst
   import fc_pkg::*;
#(
   parameter int CNT_W          = 7,
   parameter bit RTS_ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] level_i,
   input  logic [CNT_W-1:0] halt_bytes_i,
   input  logic [CNT_W-1:0] resume_bytes_i,
   input  logic             auto_en_i,
   input  logic             manual_assert_i,
   output logic             rts_pin_o
);
   localparam logic PIN_IDLE = RTS_ACTIVE_LOW ? 1'b1 : 1'b0;

   fc_rts_state_e state_q, state_d;
   logic          assert_d;
   logic          pin_d;
   logic          pin_q;

   always_comb begin
      state_d = FC_FLOW_ON;
      if (auto_en_i) begin
         if (level_i >= halt_bytes_i)
            state_d = FC_FLOW_HALTED;
         else if (state_q == FC_FLOW_HALTED && level_i > resume_bytes_i)
            state_d = FC_FLOW_HALTED;
         else
            state_d = FC_FLOW_ON;
      end
   end

   assign assert_d = auto_en_i ? (state_d == FC_FLOW_ON) : manual_assert_i;

   if (RTS_ACTIVE_LOW) begin : g_pin_low
      assign pin_d = ~assert_d;
   end else begin : g_pin_high
      assign pin_d = assert_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FC_FLOW_ON;
         pin_q   <= PIN_IDLE;
      end else begin
         state_q <= state_d;
         pin_q   <= pin_d;
      end
   end

   assign rts_pin_o = pin_q;

   assert_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en_i && level_i >= halt_bytes_i) |=> (rts_pin_o == PIN_IDLE));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en_i && state_q == FC_FLOW_HALTED && level_i > resume_bytes_i)
      |=> (state_q == FC_FLOW_HALTED && rts_pin_o == PIN_IDLE));

   assert_flow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en_i && state_q == FC_FLOW_ON && level_i < halt_bytes_i)
      |=> (rts_pin_o != PIN_IDLE));

   assert_manual_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_en_i) |=> ((rts_pin_o != PIN_IDLE) == $past(manual_assert_i)
                        && state_q == FC_FLOW_ON));
endmodule

// File: rtl/fc_cts_gate.sv
module fc_cts_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_en_i,
   input  logic cts_n_i,
   input  logic tx_busy_i,
   input  logic char_done_i,
   output logic tx_permit_o
);
   logic boundary;
   logic permit_q;

   assign boundary = !tx_busy_i || char_done_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         permit_q <= 1'b1;
      else if (boundary)
         permit_q <= !auto_en_i || !cts_n_i;
   end

   assign tx_permit_o = permit_q;

   assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en_i && cts_n_i && (!tx_busy_i || char_done_i)) |=> !tx_permit_o);

   assert_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en_i && !cts_n_i && (!tx_busy_i || char_done_i)) |=> tx_permit_o);

   assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_en_i && (!tx_busy_i || char_done_i)) |=> tx_permit_o);

   assert_midchar_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy_i && !char_done_i) |=> $stable(tx_permit_o));
endmodule

// File: rtl/fc_flow_ctrl.sv
module fc_flow_ctrl
   import fc_pkg::*;
#(
   parameter int FIFO_DEPTH     = 64,
   parameter int CODE_W         = 4,
   parameter int SCALE          = 4,
   parameter bit RTS_ACTIVE_LOW = 1'b1,
   localparam int CNT_W         = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  rx_level,
   input  logic [2*CODE_W-1:0] flow_thresh,
   input  logic              auto_rts_en,
   input  logic              auto_cts_en,
   input  logic              manual_rts,
   input  logic              cts_n,
   input  logic              tx_busy,
   input  logic              char_done,
   output logic              rts_pin,
   output logic              tx_permit
);
   if (((1 << CODE_W) - 1) * SCALE > FIFO_DEPTH) begin : g_bad_scale
      $error("fc_flow_ctrl: largest threshold exceeds the FIFO depth");
   end
   if (CODE_W != 4) begin : g_bad_code
      $error("fc_flow_ctrl: threshold field layout expects 4-bit codes");
   end

   fc_thresh_t       thr;
   logic [CNT_W-1:0] halt_bytes;
   logic [CNT_W-1:0] resume_bytes;

   assign thr = fc_thresh_t'(flow_thresh);

   fc_thresh_decode #(.CODE_W(CODE_W), .SCALE(SCALE), .CNT_W(CNT_W)) u_halt_dec (
      .code_i  (thr.halt_code),
      .bytes_o (halt_bytes)
   );

   fc_thresh_decode #(.CODE_W(CODE_W), .SCALE(SCALE), .CNT_W(CNT_W)) u_resume_dec (
      .code_i  (thr.resume_code),
      .bytes_o (resume_bytes)
   );

   fc_rts_hyst #(.CNT_W(CNT_W), .RTS_ACTIVE_LOW(RTS_ACTIVE_LOW)) u_rts (
      .clk             (clk),
      .rst_n           (rst_n),
      .level_i         (rx_level),
      .halt_bytes_i    (halt_bytes),
      .resume_bytes_i  (resume_bytes),
      .auto_en_i       (auto_rts_en),
      .manual_assert_i (manual_rts),
      .rts_pin_o       (rts_pin)
   );

   fc_cts_gate u_cts (
      .clk         (clk),
      .rst_n       (rst_n),
      .auto_en_i   (auto_cts_en),
      .cts_n_i     (cts_n),
      .tx_busy_i   (tx_busy),
      .char_done_i (char_done),
      .tx_permit_o (tx_permit)
   );

   assert_level_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level <= CNT_W'(FIFO_DEPTH));
endmodule

// File: tb/fc_flow_ctrl_tb.sv
`timescale 1ns/1ps
module fc_flow_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [6:0] rx_level;
   logic [7:0] flow_thresh;
   logic       auto_rts_en, auto_cts_en, manual_rts, cts_n, tx_busy, char_done;
   logic       rts_pin, tx_permit;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;
   bit  exp_halted = 1'b0;

   always #2.5 clk = ~clk;

   fc_flow_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .flow_thresh(flow_thresh),
      .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .manual_rts(manual_rts),
      .cts_n(cts_n), .tx_busy(tx_busy), .char_done(char_done),
      .rts_pin(rts_pin), .tx_permit(tx_permit)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b (level=%0d thresh=%h)",
                  req, act, exp, rx_level, flow_thresh);
      end
   endtask

   // drive at a falling edge, let one rising edge pass, return at next falling edge
   task automatic apply_level(input int lvl);
      int halt_b, res_b;
      string tag;
      rx_level = 7'(lvl);
      halt_b = int'(flow_thresh[3:0]) * 4;
      res_b  = int'(flow_thresh[7:4]) * 4;
      if (lvl >= halt_b) tag = "R2";
      else if (exp_halted && lvl > res_b) tag = "R3";
      else if (exp_halted) tag = "R3_release";
      else tag = "R4";
      exp_halted = (lvl >= halt_b) || (exp_halted && lvl > res_b);
      @(negedge clk);
      check(tag, rts_pin, exp_halted);
   endtask

   task automatic cts_step(input logic a, input logic c, input logic b,
                           input logic d, input logic prior);
      logic exp;
      string tag;
      auto_cts_en = a; cts_n = c; tx_busy = b; char_done = d;
      if (b && !d) begin exp = prior; tag = "R9"; end
      else if (!a) begin exp = 1'b1; tag = "R8"; end
      else begin exp = !c; tag = "R7"; end
      @(negedge clk);
      check(tag, tx_permit, exp);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; rx_level = '0; flow_thresh = 8'h00;
      auto_rts_en = 1'b0; auto_cts_en = 1'b0; manual_rts = 1'b0;
      cts_n = 1'b0; tx_busy = 1'b0; char_done = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", rts_pin, 1'b1);
      check("R1", tx_permit, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", rts_pin, 1'b1);
      check("R1", tx_permit, 1'b1);

      // R5: field placement and scaling, stop code 3 (12), restart code 2 (8)
      auto_rts_en = 1'b1; flow_thresh = 8'h23; exp_halted = 1'b0;
      rx_level = 7'd11; @(negedge clk); check("R5", rts_pin, 1'b0);
      rx_level = 7'd12; @(negedge clk); check("R5", rts_pin, 1'b1);
      rx_level = 7'd9;  @(negedge clk); check("R5", rts_pin, 1'b1);
      rx_level = 7'd8;  @(negedge clk); check("R5", rts_pin, 1'b0);
      exp_halted = 1'b0;

      // exhaustive code pairs, fill ramp then drain ramp
      for (int h = 0; h < 16; h++) begin
         for (int r = 0; r < 16; r++) begin
            flow_thresh = {4'(r), 4'(h)};
            for (int l = 0; l <= 64; l++) apply_level(l);
            for (int l = 64; l >= 0; l--) apply_level(l);
         end
      end

      // R6: manual control and clearing of the halted state
      flow_thresh = 8'h0F; apply_level(64);
      check("R6_pre", rts_pin, 1'b1);
      auto_rts_en = 1'b0; manual_rts = 1'b1; exp_halted = 1'b0;
      @(negedge clk); check("R6", rts_pin, 1'b0);
      manual_rts = 1'b0;
      @(negedge clk); check("R6", rts_pin, 1'b1);
      manual_rts = 1'b1; rx_level = 7'd64;
      @(negedge clk); check("R6", rts_pin, 1'b0);
      auto_rts_en = 1'b1; manual_rts = 1'b0; rx_level = 7'd10;
      @(negedge clk); check("R6", rts_pin, 1'b0);

      // CTS side: every input combination from each prior permit value
      for (int p = 0; p < 2; p++) begin
         for (int k = 0; k < 16; k++) begin
            cts_step(1'b1, p[0] ? 1'b0 : 1'b1, 1'b0, 1'b0, 1'b0);
            cts_step(k[3], k[2], k[1], k[0], p[0]);
         end
      end

      // R9: CTS drops mid-character, stop waits for the strobe
      cts_step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 5; i++) cts_step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
      cts_step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 3; i++) cts_step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      cts_step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      cts_step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule